// File: doc/BRIEF.md
# Packed Pairwise Add/Subtract Unit

This block reduces neighbouring element pairs inside each of two packed operands, `opA` and `opB`. Each operand is split into 16-bit or 32-bit elements. Every even/odd pair of elements within one operand is summed, or differenced, into one result element. The pair results taken from `opA` form the low half of the result vector, and the pair results taken from `opB` form the high half. For 16-bit elements an optional clamping mode keeps each sum or difference inside the signed 16-bit range instead of letting it wrap.

A narrow mode works on only the low 64 bits of each operand and packs its results into the low 64 bits of the output. A one-cycle `start` pulse samples the operands and the mode selects. The registered result appears on the next clock edge together with a one-cycle `resultValid` pulse, and it stays unchanged until the next `start`.

Top module: `hpair_unit`

## Requirements
- R1: While `rstN` is low, `result` is all zeros and `resultValid` is 0.
- R2: `resultValid` is 1 in exactly the cycle after a cycle in which `start` is 1, and that cycle carries the result computed from the inputs sampled with `start`. In every other cycle `resultValid` is 0.
- R3: Every result element comes from one adjacent pair (element 2k and element 2k+1) of a single operand. The `opA` pairs fill the lower half of the active output width in increasing k, and the `opB` pairs fill the upper half.
- R4: With `wideLanes`=0 (16-bit elements) and `satMode`=0, sums and differences wrap modulo 2^16.
- R5: With `subMode`=1, each result is element 2k minus element 2k+1. With `subMode`=0, it is their sum.
- R6: With `wideLanes`=1 (32-bit elements), results wrap modulo 2^32. In full width this gives 4 results, and with `halfMode`=1 it gives 2.
- R7: With `satMode`=1 and 16-bit elements, a result above 0x7FFF becomes 0x7FFF and a result below -0x8000 becomes 0x8000. In-range results are unchanged.
- R8: With `halfMode`=1, only bits 63:0 of each operand are used. For 16-bit elements this gives 4 results: two from `opA`, then two from `opB`. Bits 127:64 of `result` are zero.
- R9: The combination `satMode`=1 with `wideLanes`=1 is illegal and produces an all-zero result. `resultValid` still pulses.
- R10: While `start` is 0, `result` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Samples operands and selects this cycle |
| wideLanes | input | 1 | 0: 16-bit elements, 1: 32-bit elements |
| subMode | input | 1 | 0: add pair, 1: even minus odd |
| satMode | input | 1 | 1: clamp 16-bit results to the signed range |
| halfMode | input | 1 | 1: use the low 64 operand bits only |
| opA | input | 128 | First operand; its pairs fill the low result half |
| opB | input | 128 | Second operand; its pairs fill the high result half |
| result | output | 128 | Registered packed pair results |
| resultValid | output | 1 | One-cycle pulse marking a new result |

## Verification
Every result is due exactly one rising edge after the cycle that carries `start`. The bench raises `start` for one cycle just after a falling edge and reads `result` and `resultValid` at the following falling edge, half a period after the capturing edge. One falling edge later it checks that `resultValid` has dropped and that `result` has kept its value. Expected values come from a behavioural model in the bench that walks the element pairs by index, and a set of hand-computed vectors covers clamping, subtraction order and narrow mode.

// File: rtl/hpair_pkg.sv
package hpair_pkg;

  typedef struct packed {
    logic capture;
    logic zeroOut;
    logic wide;
    logic sub;
    logic sat;
    logic half;
  } hpair_strb_t;

  function automatic logic [15:0] pairOp16(input logic [15:0] lo,
                                           input logic [15:0] hi,
                                           input logic sub,
                                           input logic sat);
    logic signed [16:0] ext;
    logic [15:0] outv;
    if (sub) ext = $signed({lo[15], lo}) - $signed({hi[15], hi});
    else     ext = $signed({lo[15], lo}) + $signed({hi[15], hi});
    outv = ext[15:0];
    if (sat && (ext[16] != ext[15])) outv = ext[16] ? 16'h8000 : 16'h7FFF;
    return outv;
  endfunction

  function automatic logic [31:0] pairOp32(input logic [31:0] lo,
                                           input logic [31:0] hi,
                                           input logic sub);
    return sub ? (lo - hi) : (lo + hi);
  endfunction

endpackage

// File: rtl/hpair_ctrl.sv
module hpair_ctrl
  import hpair_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        wideLanes,
  input  logic        subMode,
  input  logic        satMode,
  input  logic        halfMode,
  output hpair_strb_t strb,
  output logic        validOut
);

  logic illegalSel;
  assign illegalSel = satMode & wideLanes;

  always_comb begin
    strb.capture = start;
    strb.zeroOut = illegalSel;
    strb.wide    = wideLanes;
    strb.sub     = subMode;
    strb.sat     = satMode & ~wideLanes;
    strb.half    = halfMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) validOut <= 1'b0;
    else       validOut <= start;
  end

endmodule

// File: rtl/hpair_dp.sv
module hpair_dp
  import hpair_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  hpair_strb_t       strb,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] resOut
);

  localparam int N16   = DATA_W / 16;
  localparam int P16F  = N16 / 2;
  localparam int P16H  = N16 / 4;
  localparam int N32   = DATA_W / 32;
  localparam int P32F  = N32 / 2;
  localparam int P32H  = N32 / 4;
  localparam int HALFW = DATA_W / 2;

  logic [DATA_W-1:0] full16, half16, full32, half32, picked;

  // full-width, 16-bit elements
  for (genvar j = 0; j < P16F; j++) begin : g_f16
    assign full16[j*16 +: 16] =
      pairOp16(opA[(2*j)*16 +: 16], opA[(2*j+1)*16 +: 16], strb.sub, strb.sat);
    assign full16[(j+P16F)*16 +: 16] =
      pairOp16(opB[(2*j)*16 +: 16], opB[(2*j+1)*16 +: 16], strb.sub, strb.sat);
  end

  // narrow mode, 16-bit elements
  for (genvar j = 0; j < P16H; j++) begin : g_h16
    assign half16[j*16 +: 16] =
      pairOp16(opA[(2*j)*16 +: 16], opA[(2*j+1)*16 +: 16], strb.sub, strb.sat);
    assign half16[(j+P16H)*16 +: 16] =
      pairOp16(opB[(2*j)*16 +: 16], opB[(2*j+1)*16 +: 16], strb.sub, strb.sat);
  end
  assign half16[DATA_W-1:HALFW] = '0;

  // full-width, 32-bit elements
  for (genvar j = 0; j < P32F; j++) begin : g_f32
    assign full32[j*32 +: 32] =
      pairOp32(opA[(2*j)*32 +: 32], opA[(2*j+1)*32 +: 32], strb.sub);
    assign full32[(j+P32F)*32 +: 32] =
      pairOp32(opB[(2*j)*32 +: 32], opB[(2*j+1)*32 +: 32], strb.sub);
  end

  // narrow mode, 32-bit elements
  for (genvar j = 0; j < P32H; j++) begin : g_h32
    assign half32[j*32 +: 32] =
      pairOp32(opA[(2*j)*32 +: 32], opA[(2*j+1)*32 +: 32], strb.sub);
    assign half32[(j+P32H)*32 +: 32] =
      pairOp32(opB[(2*j)*32 +: 32], opB[(2*j+1)*32 +: 32], strb.sub);
  end
  assign half32[DATA_W-1:HALFW] = '0;

  always_comb begin
    unique case ({strb.wide, strb.half})
      2'b00:   picked = full16;
      2'b01:   picked = half16;
      2'b10:   picked = full32;
      default: picked = half32;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)             resOut <= '0;
    else if (strb.capture) resOut <= strb.zeroOut ? '0 : picked;
  end

endmodule

// File: rtl/hpair_unit.sv
module hpair_unit
  import hpair_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              wideLanes,
  input  logic              subMode,
  input  logic              satMode,
  input  logic              halfMode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              resultValid
);

  hpair_strb_t strb;

  hpair_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .wideLanes(wideLanes),
    .subMode  (subMode),
    .satMode  (satMode),
    .halfMode (halfMode),
    .strb     (strb),
    .validOut (resultValid)
  );

  hpair_dp #(.DATA_W(DATA_W)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .opA   (opA),
    .opB   (opB),
    .resOut(result)
  );

endmodule

// File: rtl/hpair_checks.sv
module hpair_checks #(
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              wideLanes,
  input logic              subMode,
  input logic              satMode,
  input logic              halfMode,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [DATA_W-1:0] result,
  input logic              resultValid
);

  a_r2_valid_after_start: assert property (@(posedge clk) disable iff (!rstN)
    start |=> resultValid);

  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !resultValid);

  a_r10_hold_result: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> $stable(result));

  a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (start && halfMode) |=> (result[DATA_W-1:DATA_W/2] == '0));

  a_r9_illegal_zero: assert property (@(posedge clk) disable iff (!rstN)
    (start && satMode && wideLanes) |=> (result == '0));

  a_r7_sat_ones_pair: assert property (@(posedge clk) disable iff (!rstN)
    (start && satMode && !wideLanes && !subMode &&
     opA[15:0] == 16'h7FFF && opA[31:16] == 16'h7FFF) |=> (result[15:0] == 16'h7FFF));

endmodule

bind hpair_unit hpair_checks #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_hpair_unit.sv
`timescale 1ns/1ps
module sim_hpair_unit;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic         wideLanes = 1'b0, subMode = 1'b0, satMode = 1'b0, halfMode = 1'b0;
  logic [127:0] opA = '0, opB = '0;
  logic [127:0] result;
  logic         resultValid;

  int nRun = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  hpair_unit u0 (.*);

  // reference model: walks element pairs by index
  function automatic logic [127:0] refModel(input logic [127:0] a, input logic [127:0] b,
                                            input logic wide, input logic sub,
                                            input logic sat, input logic half);
    logic [127:0] acc = '0;
    logic [127:0] mask;
    int ew, np;
    if (sat && wide) return '0;
    ew   = wide ? 32 : 16;
    np   = (half ? 64 : 128) / ew / 2;
    mask = wide ? 128'hFFFF_FFFF : 128'hFFFF;
    for (int src = 0; src < 2; src++) begin
      for (int k = 0; k < np; k++) begin
        logic [127:0] op, xv, yv;
        longint sx, sy, r;
        op = (src == 0) ? a : b;
        xv = (op >> (2*k*ew)) & mask;
        yv = (op >> ((2*k+1)*ew)) & mask;
        if (wide) begin
          sx = longint'($signed(xv[31:0]));
          sy = longint'($signed(yv[31:0]));
        end else begin
          sx = longint'($signed(xv[15:0]));
          sy = longint'($signed(yv[15:0]));
        end
        r = sub ? sx - sy : sx + sy;
        if (sat && !wide) begin
          if (r > 32767)  r = 32767;
          if (r < -32768) r = -32768;
        end
        acc = acc | ((128'(r) & mask) << ((src*np + k)*ew));
      end
    end
    return acc;
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one operation: drive after negedge, sample at next negedge, then check hold
  task automatic runOp(input string tag, input logic [127:0] a, input logic [127:0] b,
                       input logic [3:0] sel, input logic [127:0] exp);
    logic [127:0] held;
    @(negedge clk);
    opA = a; opB = b;
    {wideLanes, subMode, satMode, halfMode} = sel;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({tag, " R2 valid"}, {127'b0, resultValid}, 128'd1);
    check(tag, result, exp);
    held = result;
    opA = ~a; opB = ~b;
    @(negedge clk);
    check({tag, " R2 valid drop"}, {127'b0, resultValid}, 128'd0);
    check({tag, " R10 hold"}, result, held);
  endtask

  // stimulus table: {wide, sub, sat, half, opA, opB}
  localparam int NT = 6;
  localparam logic [259:0] TBL [NT] = '{
    {4'b0000, 128'h0008_0007_0006_0005_0004_0003_0002_0001,
              128'h0018_0017_0016_0015_0014_0013_0012_0011},
    {4'b0100, 128'h1234_8000_7FFF_0001_FFFF_0005_0003_000A,
              128'h0000_0001_8000_8000_7FFF_7FFF_0010_0001},
    {4'b1000, 128'h0000_0004_0000_0003_0000_0002_FFFF_FFFF,
              128'h8000_0000_8000_0000_0000_0010_0000_0020},
    {4'b1100, 128'h0000_0001_0000_0000_0000_0005_0000_0009,
              128'h7FFF_FFFF_FFFF_FFFF_1111_1111_2222_2222},
    {4'b0011, 128'hAAAA_AAAA_AAAA_AAAA_7FFF_0100_8000_8000,
              128'h5555_5555_5555_5555_0001_8000_7FFF_7FFF},
    {4'b1001, 128'hDEAD_BEEF_DEAD_BEEF_0000_0003_0000_0007,
              128'hCAFE_F00D_CAFE_F00D_0000_0010_FFFF_FFF0}
  };

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 reset result", result, '0);
    check("R1 reset valid", {127'b0, resultValid}, '0);
    rstN = 1'b1;

    // R3 R4 R5 R6 R8: table walk against the model
    for (int i = 0; i < NT; i++) begin
      runOp("R3 table", TBL[i][255:128], TBL[i][127:0], TBL[i][259:256],
            refModel(TBL[i][255:128], TBL[i][127:0], TBL[i][259], TBL[i][258],
                     TBL[i][257], TBL[i][256]));
    end

    // R3 ordering, literal: pairs of A low, B high
    runOp("R3 order", 128'h0008_0007_0006_0005_0004_0003_0002_0001,
          128'h0018_0017_0016_0015_0014_0013_0012_0011, 4'b0000,
          128'h002F_002B_0027_0023_000F_000B_0007_0003);
    // R5: even minus odd
    runOp("R5 sub order", {112'b0, 16'h0003, 16'h0005} , '0, 4'b0100,
          128'h0000_0000_0000_0000_0000_0000_0000_0002);
    // R4: wrap without saturation
    runOp("R4 wrap", {96'b0, 16'h0001, 16'h7FFF}, '0, 4'b0000,
          {112'b0, 16'h8000});
    // R7: positive clamp
    runOp("R7 sat pos", {96'b0, 16'h0001, 16'h7FFF}, '0, 4'b0010,
          {112'b0, 16'h7FFF});
    // R7: negative clamp via subtraction
    runOp("R7 sat neg", {96'b0, 16'h0001, 16'h8000}, '0, 4'b0110,
          {112'b0, 16'h8000});
    // R7: in range stays exact
    runOp("R7 sat in range", {96'b0, 16'hFFFE, 16'h0005}, '0, 4'b0010,
          {112'b0, 16'h0003});
    // R6: 32-bit wrap
    runOp("R6 wrap32", {64'b0, 32'h0000_0001, 32'hFFFF_FFFF}, '0, 4'b1000, '0);
    // R8: narrow mode ignores upper operand bits
    runOp("R8 half16", {64'hFFFF_FFFF_FFFF_FFFF, 16'h0004, 16'h0003, 16'h0002, 16'h0001},
          {64'h1234_5678_9ABC_DEF0, 16'h0040, 16'h0030, 16'h0020, 16'h0010}, 4'b0001,
          {64'b0, 16'h0070, 16'h0030, 16'h0007, 16'h0003});
    // R9: illegal select
    runOp("R9 illegal", 128'h1, 128'h2, 4'b1010, '0);

    // random sweep over all modes
    for (int m = 0; m < 16; m++) begin
      for (int n = 0; n < 12; n++) begin
        logic [127:0] ra, rb;
        ra = {$urandom, $urandom, $urandom, $urandom};
        rb = {$urandom, $urandom, $urandom, $urandom};
        if (n == 0) begin ra = {8{16'h7FFF}}; rb = {8{16'h8000}}; end
        runOp("R3 random", ra, rb, 4'(m),
              refModel(ra, rb, m[3], m[2], m[1], m[0]));
      end
    end

    // R1: reset mid-run clears state
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset again", result, '0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule